// File: doc/BRIEF.md
# Serial EEPROM Target with Write-Protect Window

This block is the front end of a small serial EEPROM that answers as a target on a two-wire I2C bus. It takes SCL and SDA from the pads, runs them through a synchronizer and a digital glitch filter clocked by a fast system clock, and recognizes START and STOP. It then shifts in a device-address byte, a word-address byte and a data byte. It answers each accepted byte with an ACK pulled low through an open-drain enable, and for reads it streams stored bytes with an auto-incrementing pointer. The storage is a register array.

A write is not committed when its STOP arrives. The STOP starts an internal programming interval, counted in system clocks, and the data lands in the array when that interval ends. While the interval runs, the block ignores its own address, so a host can poll until the address is acknowledged again. A write-protect input is watched over a window. It needs a minimum width before the block acts on it. If it is seen while a byte write is still being entered, the pending write is dropped. If it is seen during the programming interval, the write stops at once, the target location is overwritten with a marker value, and a status output asks for a rewrite.

Top module: `sereep_target`

## Requirements
- R1: A pulse on SCL or SDA that lasts fewer than FILT_N system clocks has no effect on the protocol: a byte write that carries such glitches on both lines stores its data byte unchanged.
- R2: SDA falling while SCL is high is a START and restarts reception of a device address from any state. SDA rising while SCL is high is a STOP. A STOP that follows no accepted data byte starts no programming interval.
- R3: The first byte after START is compared in bits 7:1 against {DEV_HI, strap_i}, with DEV_HI defaulting to 4'b1010. Bit 0 selects the direction: 0 is write, 1 is read. A mismatch gets no ACK, and the block stays silent until the next START.
- R4: SDA is sampled on rising SCL. sda_oe changes only while the filtered SCL is low, after a falling edge. Every accepted byte is acknowledged by driving SDA low for the ninth clock.
- R5: A byte write is device address (write), word address (the low AW bits index the array), one data byte, then STOP. After the STOP, busy_o is high for TWR_CYC system clocks, and the array then holds the byte. A second data byte in the same write gets no ACK and is discarded.
- R6: While busy_o is high, the device address gets no ACK and sda_oe stays low.
- R7: If write protect is qualified high after the rising SCL that captures bit 0 of the first data byte and before the STOP, the write is discarded and busy_o does not rise. Write protect that is high only before that edge has no effect.
- R8: Write protect must stay high for WP_MIN consecutive system clocks before it is qualified. Shorter pulses neither cancel nor abort a write.
- R9: Qualified write protect during the programming interval drops busy_o on the next clock, writes 8'hFF into the target location and sets rewrite_o. rewrite_o is cleared when a later write completes.
- R10: A read sends bytes MSB first from the pointer and advances it, wrapping at DEPTH. A host ACK continues the read. A host NACK ends it, and SDA is released.
- R11: After reset, sda_oe, busy_o and rewrite_o are low and every array location reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| wp_i | input | 1 | Write-protect request, active high |
| strap_i | input | 3 | Address strap bits compared with device-address bits 3:1 |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| busy_o | output | 1 | Internal programming interval in progress |
| rewrite_o | output | 1 | Last write was aborted; contents must be rewritten |

## Verification
The bench drives both bus lines from a bit-level host model and aims at the write-protect window edges. A pulse before bit 0 of the data byte must leave the write alone. A pulse after it must cancel the write. A pulse too short to qualify must be ignored. A pulse during programming must abort the write and leave 8'hFF. A window opened one bit late, or a qualifier that skips the width check, shows up as a stored byte that differs from the reference array. Glitches shorter than the filter are injected on SCL while it is low and on SDA while SCL is high. A weak filter would shift in an extra bit or see a false START/STOP and corrupt the stored value. Busy polling checks that the address is not acknowledged during programming. A read that crosses the top of the array catches a pointer that fails to wrap.

// File: rtl/sereep_pkg.sv
package sereep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADR,
    ST_WDAT,
    ST_ACKW,
    ST_RDAT,
    ST_ACKR,
    ST_IGN
  } st_e;
endpackage

// File: rtl/sereep_deglitch.sv
// Two-flop synchronizer followed by a run-length filter: the output follows
// the input only after N consecutive samples disagree with it.
module sereep_deglitch #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(N + 1);

  logic s1_q, s2_q, out_q, out_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    out_d = out_q;
    cnt_d = '0;
    if (s2_q != out_q) begin
      if (cnt_q == CW'(N - 1)) begin
        out_d = s2_q;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      out_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      s1_q  <= din;
      s2_q  <= s1_q;
      out_q <= out_d;
      cnt_q <= cnt_d;
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/sereep_wpqual.sv
// Minimum-width qualifier: q rises after MIN consecutive high samples.
module sereep_wpqual #(
  parameter int MIN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wp,
  output logic q
);
  localparam int CW = $clog2(MIN + 1);

  logic s1_q, s2_q;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!s2_q) begin
      cnt_d = '0;
    end else if (cnt_q != CW'(MIN)) begin
      cnt_d = cnt_q + CW'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q  <= wp;
      s2_q  <= s1_q;
      cnt_q <= cnt_d;
    end
  end

  assign q = (cnt_q == CW'(MIN));
endmodule

// File: rtl/sereep_target.sv
module sereep_target
  import sereep_pkg::*;
#(
  parameter int         FILT_N  = 4,
  parameter int         WP_MIN  = 8,
  parameter int         TWR_CYC = 2000,
  parameter int         DEPTH   = 16,
  parameter logic [3:0] DEV_HI  = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       wp_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe,
  output logic       busy_o,
  output logic       rewrite_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int TW = $clog2(TWR_CYC);
  localparam logic [TW-1:0] TLAST = TW'(TWR_CYC - 1);

  // reset: asserted asynchronously, released on the clock
  logic rs1_q, rs2_q, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_s = rs2_q;

  logic scl_f, sda_f, wp_q;
  sereep_deglitch #(.N(FILT_N)) u_flt_scl (.clk(clk), .rst_n(rst_s), .din(scl_i), .dout(scl_f));
  sereep_deglitch #(.N(FILT_N)) u_flt_sda (.clk(clk), .rst_n(rst_s), .din(sda_i), .dout(sda_f));
  sereep_wpqual   #(.MIN(WP_MIN)) u_wpq   (.clk(clk), .rst_n(rst_s), .wp(wp_i), .q(wp_q));

  logic scl_p, sda_p;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;

  st_e           st_q, st_d, post_q, post_d;
  logic [6:0]    sh_q, sh_d;
  logic [3:0]    bcnt_q, bcnt_d;
  logic          oe_q, oe_d, got_q, got_d, pend_q, pend_d;
  logic          win_q, win_d, cancel_q, cancel_d;
  logic          ackit_q, ackit_d, more_q, more_d;
  logic          busy_q, busy_d, rewr_q, rewr_d;
  logic [AW-1:0] ptr_q, ptr_d, paddr_q, paddr_d;
  logic [7:0]    pdat_q, pdat_d;
  logic [TW-1:0] tcnt_q, tcnt_d;

  logic [7:0]    mem_q [DEPTH];
  logic          mwe;
  logic [AW-1:0] mwa;
  logic [7:0]    mwd;
  logic [7:0]    rd_byte;
  assign rd_byte = mem_q[ptr_q];

  always_comb begin
    st_d = st_q;     post_d = post_q;   sh_d = sh_q;       bcnt_d = bcnt_q;
    oe_d = oe_q;     got_d = got_q;     pend_d = pend_q;   win_d = win_q;
    ackit_d = ackit_q; more_d = more_q; busy_d = busy_q;   rewr_d = rewr_q;
    ptr_d = ptr_q;   paddr_d = paddr_q; pdat_d = pdat_q;   tcnt_d = tcnt_q;
    cancel_d = cancel_q | (win_q & wp_q);
    mwe = 1'b0;
    mwa = paddr_q;
    mwd = pdat_q;

    if (start_ev) begin
      st_d = ST_DEV;  bcnt_d = '0;  oe_d = 1'b0;
      got_d = 1'b0;   pend_d = 1'b0; win_d = 1'b0; cancel_d = 1'b0;
    end else if (stop_ev) begin
      st_d = ST_IDLE; oe_d = 1'b0; win_d = 1'b0; pend_d = 1'b0;
      if (pend_q && !cancel_d && !busy_q) begin
        busy_d  = 1'b1;
        tcnt_d  = '0;
        paddr_d = ptr_q;
      end
    end else begin
      unique case (st_q)
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (scl_rise && bcnt_q != 4'd8) begin
            sh_d   = {sh_q[5:0], sda_f};
            bcnt_d = bcnt_q + 4'd1;
            if (bcnt_q == 4'd7) begin
              if (st_q == ST_DEV) begin
                ackit_d = (sh_q == {DEV_HI, strap_i}) && !busy_q;
                post_d  = sda_f ? ST_RDAT : ST_WADR;
              end else if (st_q == ST_WADR) begin
                ackit_d = 1'b1;
                post_d  = ST_WDAT;
              end else begin
                ackit_d = !got_q;
                post_d  = ST_WDAT;
                if (!got_q) begin
                  got_d  = 1'b1;
                  pend_d = 1'b1;
                  pdat_d = {sh_q, sda_f};
                  win_d  = 1'b1;
                end
              end
            end
          end else if (scl_fall && bcnt_q == 4'd8) begin
            if (ackit_q) begin
              oe_d = 1'b1;
              st_d = ST_ACKW;
              if (st_q == ST_WADR) ptr_d = sh_q[AW-1:0];
            end else begin
              st_d = ST_IGN;
            end
          end
        end
        ST_ACKW: begin
          if (scl_fall) begin
            bcnt_d = '0;
            if (post_q == ST_RDAT) begin
              sh_d   = rd_byte[6:0];
              oe_d   = !rd_byte[7];
              bcnt_d = 4'd1;
              ptr_d  = ptr_q + AW'(1);
              st_d   = ST_RDAT;
            end else begin
              oe_d = 1'b0;
              st_d = post_q;
            end
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (bcnt_q == 4'd8) begin
              oe_d = 1'b0;
              st_d = ST_ACKR;
            end else begin
              oe_d   = !sh_q[6];
              sh_d   = {sh_q[5:0], 1'b0};
              bcnt_d = bcnt_q + 4'd1;
            end
          end
        end
        ST_ACKR: begin
          if (scl_rise) begin
            more_d = !sda_f;
          end else if (scl_fall) begin
            if (more_q) begin
              sh_d   = rd_byte[6:0];
              oe_d   = !rd_byte[7];
              bcnt_d = 4'd1;
              ptr_d  = ptr_q + AW'(1);
              st_d   = ST_RDAT;
            end else begin
              oe_d = 1'b0;
              st_d = ST_IGN;
            end
          end
        end
        default: ;
      endcase
    end

    // internal programming interval
    if (busy_q) begin
      if (wp_q) begin
        busy_d = 1'b0;
        rewr_d = 1'b1;
        mwe    = 1'b1;
        mwd    = 8'hFF;
      end else if (tcnt_q == TLAST) begin
        busy_d = 1'b0;
        rewr_d = 1'b0;
        mwe    = 1'b1;
      end else begin
        tcnt_d = tcnt_q + TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      scl_p <= 1'b1;   sda_p <= 1'b1;
      st_q <= ST_IDLE; post_q <= ST_IDLE; sh_q <= '0;     bcnt_q <= '0;
      oe_q <= 1'b0;    got_q <= 1'b0;     pend_q <= 1'b0; win_q <= 1'b0;
      cancel_q <= 1'b0; ackit_q <= 1'b0;  more_q <= 1'b0;
      busy_q <= 1'b0;  rewr_q <= 1'b0;    ptr_q <= '0;    paddr_q <= '0;
      pdat_q <= '0;    tcnt_q <= '0;
    end else begin
      scl_p <= scl_f;  sda_p <= sda_f;
      st_q <= st_d;    post_q <= post_d;  sh_q <= sh_d;   bcnt_q <= bcnt_d;
      oe_q <= oe_d;    got_q <= got_d;    pend_q <= pend_d; win_q <= win_d;
      cancel_q <= cancel_d; ackit_q <= ackit_d; more_q <= more_d;
      busy_q <= busy_d; rewr_q <= rewr_d; ptr_q <= ptr_d; paddr_q <= paddr_d;
      pdat_q <= pdat_d; tcnt_q <= tcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (mwe) begin
      mem_q[mwa] <= mwd;
    end
  end

  assign sda_oe    = oe_q;
  assign busy_o    = busy_q;
  assign rewrite_o = rewr_q;
endmodule

// File: rtl/sereep_target_chk.sv
module sereep_target_chk
  import sereep_pkg::*;
#(
  parameter int TWR_CYC = 2000,
  parameter int TW      = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_f,
  input logic          wp_q,
  input st_e           st,
  input logic [TW-1:0] tcnt,
  input logic          sda_oe,
  input logic          busy_o,
  input logic          rewrite_o
);
  // R4: the driver never moves while the filtered clock stays high
  p_oe_steady_scl_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe));

  // R6: no acknowledge or data while programming
  p_busy_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_oe);

  // R9: qualified write protect ends programming on the next clock
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && wp_q) |=> (!busy_o && rewrite_o));

  // R5: the interval counter stays inside its bound
  p_timer_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (tcnt < TW'(TWR_CYC)));

  // R5: each interval starts from a cleared counter
  p_timer_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (tcnt == '0));

  // R11: released bus when idle
  p_idle_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);
endmodule

bind sereep_target sereep_target_chk #(.TWR_CYC(TWR_CYC), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_s), .scl_f(scl_f), .wp_q(wp_q), .st(st_q),
  .tcnt(tcnt_q), .sda_oe(sda_oe), .busy_o(busy_o), .rewrite_o(rewrite_o)
);

// File: tb/sereep_target_bench.sv
module sereep_target_bench;
  localparam int TWR = 2000;
  localparam int Q   = 16;
  localparam logic [7:0] DEV_W = {4'hA, 3'b101, 1'b0};
  localparam logic [7:0] DEV_R = {4'hA, 3'b101, 1'b1};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, scl_h, sda_h, wp;
  logic [2:0] strap;
  logic sda_oe, busy_o, rewrite_o;
  logic sda_bus;
  assign sda_bus = sda_h & ~sda_oe;

  sereep_target #(.FILT_N(4), .WP_MIN(8), .TWR_CYC(TWR), .DEPTH(16), .DEV_HI(4'hA)) u_sereep_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus), .wp_i(wp),
    .strap_i(strap), .sda_oe(sda_oe), .busy_o(busy_o), .rewrite_o(rewrite_o)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] refm [16];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic h_start;
    sda_h = 1'b1; wt(Q); scl_h = 1'b1; wt(Q); sda_h = 1'b0; wt(Q); scl_h = 1'b0; wt(Q);
  endtask

  task automatic h_stop;
    sda_h = 1'b0; wt(Q); scl_h = 1'b1; wt(Q); sda_h = 1'b1; wt(Q);
  endtask

  // g: 0 clean, 1 short SCL pulse while low, 2 short SDA flip while SCL high
  task automatic wbit(input logic b, input int g);
    sda_h = b;
    if (g == 1) begin
      wt(Q/2); scl_h = 1'b1; wt(2); scl_h = 1'b0; wt(Q/2 - 2);
    end else begin
      wt(Q);
    end
    scl_h = 1'b1;
    if (g == 2) begin
      wt(Q - 1); sda_h = ~b; wt(2); sda_h = b; wt(Q - 1);
    end else begin
      wt(2*Q);
    end
    scl_h = 1'b0; wt(Q);
  endtask

  task automatic rbit(output logic b);
    sda_h = 1'b1; wt(Q); scl_h = 1'b1; wt(Q); b = sda_bus; wt(Q); scl_h = 1'b0; wt(Q);
  endtask

  task automatic sbyte(input logic [7:0] d, input bit glitch, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(d[i], glitch ? ((i == 5) ? 1 : (i == 2) ? 2 : 0) : 0);
    rbit(a);
    ack = ~a;
  endtask

  task automatic rbyte(input bit give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(~give_ack, 0);
  endtask

  task automatic wr_tx(input logic [3:0] a, input logic [7:0] d, output logic a0, output logic a1, output logic a2);
    h_start; sbyte(DEV_W, 1'b0, a0); sbyte({4'h0, a}, 1'b0, a1); sbyte(d, 1'b0, a2); h_stop;
  endtask

  task automatic wait_idle;
    int n = 0;
    while (busy_o && n < 20000) begin wt(1); n++; end
  endtask

  task automatic rd_tx(input logic [3:0] a, input int n, input string req);
    logic k;
    logic [7:0] d;
    h_start; sbyte(DEV_W, 1'b0, k); check(req, k, 1);
    sbyte({4'h0, a}, 1'b0, k); check(req, k, 1);
    h_start; sbyte(DEV_R, 1'b0, k); check("R2 repeated start", k, 1);
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, d);
      check(req, d, refm[(a + i) % 16]);
    end
    h_stop;
    check("R10 released after NACK", sda_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a0, a1, a2, k;
    int n;
    int unsigned seed;
    rst_n = 1'b0; scl_h = 1'b1; sda_h = 1'b1; wp = 1'b0; strap = 3'b101;
    for (int i = 0; i < 16; i++) refm[i] = 8'h00;
    wt(10);
    check("R11 sda_oe", sda_oe, 0);
    check("R11 busy", busy_o, 0);
    check("R11 rewrite", rewrite_o, 0);
    rst_n = 1'b1; wt(20);

    rd_tx(4'd0, 3, "R11 reset contents");

    // directed byte write and interval length
    wr_tx(4'd3, 8'hA5, a0, a1, a2);
    check("R4 dev ack", a0, 1); check("R4 addr ack", a1, 1); check("R5 data ack", a2, 1);
    check("R5 busy after stop", busy_o, 1);
    n = 0;
    while (busy_o && n < 20000) begin wt(1); n++; end
    check("R5 interval length", int'(n >= TWR - 30 && n <= TWR), 1);
    refm[3] = 8'hA5;
    rd_tx(4'd3, 1, "R5 stored byte");

    // busy polling
    wr_tx(4'd4, 8'h3C, a0, a1, a2);
    h_start; sbyte(DEV_W, 1'b0, k); h_stop;
    check("R6 NACK while busy", k, 0);
    wait_idle;
    h_start; sbyte(DEV_W, 1'b0, k); h_stop;
    check("R6 ACK after interval", k, 1);
    check("R2 stop without data starts nothing", busy_o, 0);
    refm[4] = 8'h3C;

    // second data byte refused
    h_start; sbyte(DEV_W, 1'b0, k); sbyte(8'h05, 1'b0, k); sbyte(8'h11, 1'b0, a1); sbyte(8'h22, 1'b0, a2); h_stop;
    check("R5 first data ack", a1, 1);
    check("R5 second data NACK", a2, 0);
    wait_idle; refm[5] = 8'h11;
    rd_tx(4'd5, 2, "R5 extra byte discarded");

    // wrong strap
    strap = 3'b001;
    h_start; sbyte(DEV_W, 1'b0, k); sbyte(8'h02, 1'b0, a1); sbyte(8'hEE, 1'b0, a2); h_stop;
    check("R3 mismatch NACK", k, 0);
    check("R3 mismatch no write", busy_o, 0);
    strap = 3'b101;

    // glitches on both lines
    h_start; sbyte(DEV_W, 1'b1, a0); sbyte(8'h07, 1'b1, a1); sbyte(8'h6C, 1'b1, a2); h_stop;
    check("R1 acks under glitches", {a0, a1, a2}, 3'b111);
    wait_idle; refm[7] = 8'h6C;
    rd_tx(4'd7, 1, "R1 glitched write stored");

    // cancel inside window
    h_start; sbyte(DEV_W, 1'b0, k); sbyte(8'h08, 1'b0, k); sbyte(8'h99, 1'b0, k);
    wp = 1'b1; wt(20); wp = 1'b0; wt(20); h_stop;
    check("R7 cancel no busy", busy_o, 0);
    rd_tx(4'd8, 1, "R7 cancelled write");

    // protect before window
    h_start; sbyte(DEV_W, 1'b0, k);
    wp = 1'b1; wt(20); wp = 1'b0; wt(20);
    sbyte(8'h09, 1'b0, k); sbyte(8'h42, 1'b0, k); h_stop;
    check("R7 early protect ignored", busy_o, 1);
    wait_idle; refm[9] = 8'h42;
    rd_tx(4'd9, 1, "R7 early protect write");

    // short protect pulse
    h_start; sbyte(DEV_W, 1'b0, k); sbyte(8'h0A, 1'b0, k); sbyte(8'h5A, 1'b0, k);
    wp = 1'b1; wt(4); wp = 1'b0; wt(20); h_stop;
    check("R8 short pulse ignored", busy_o, 1);
    wt(50); wp = 1'b1; wt(4); wp = 1'b0; wt(10);
    check("R8 short pulse no abort", busy_o, 1);
    wait_idle; refm[10] = 8'h5A;
    check("R8 no rewrite flag", rewrite_o, 0);
    rd_tx(4'd10, 1, "R8 short pulse write");

    // abort during interval
    wr_tx(4'd11, 8'h77, a0, a1, a2);
    wt(100); wp = 1'b1; wt(20);
    check("R9 busy dropped", busy_o, 0);
    check("R9 rewrite set", rewrite_o, 1);
    wp = 1'b0; wt(20);
    refm[11] = 8'hFF;
    rd_tx(4'd11, 1, "R9 marker value");
    wr_tx(4'd12, 8'h81, a0, a1, a2);
    wait_idle; refm[12] = 8'h81;
    check("R9 rewrite cleared", rewrite_o, 0);

    // random writes
    seed = $urandom(32'h5EED1234);
    for (int i = 0; i < 8; i++) begin
      logic [3:0] ra;
      logic [7:0] rd;
      ra = 4'($urandom % 16);
      rd = 8'($urandom);
      wr_tx(ra, rd, a0, a1, a2);
      check("R5 random write acks", {a0, a1, a2}, 3'b111);
      wait_idle;
      refm[ra] = rd;
    end

    // wrapping sequential read
    rd_tx(4'd14, 18, "R10 sequential wrap");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule